// File: doc/BRIEF.md
# Vector Length Control Registers

This block keeps three small length-control registers, one for each privilege level from 1 to 3. From them it works out the vector length code that applies at the current privilege level. Software reaches the registers through a plain write/read port addressed by a level select. Two presence inputs say whether levels 2 and 3 are implemented. A level register that is not implemented reads as zero, ignores writes and takes no part in the result.

The effective length starts from the register that belongs to the current level. It is then capped by the value of every implemented level above the current one. When the vector unit is trapped while floating point is still usable, the length is forced to zero. The result is computed combinationally from the registers and the control inputs, then registered once, so the output follows its inputs one clock edge later.

Top module: `vlen_ctrl`

## Requirements
- R1: Each register keeps only the low 4 bits of a write; `rd_data` bits above bit 3 always read as zero, and the upper bits of `wr_data` have no effect on the stored value.
- R2: Select codes are `sel`=1 for the level-1 register, 2 for level 2 and 3 for level 3. `sel`=0 addresses nothing: it reads zero and a write with it changes no register. Reads are combinational.
- R3: After reset all three registers read zero and `eff_len` is zero.
- R4: With no trap forcing and no cap from a higher level, current levels 0 and 1 (`cur_lvl` 0 or 1) use the level-1 register, level 2 uses the level-2 register and level 3 uses the level-3 register.
- R5: When `cur_lvl` is below 2 and level 2 is present, the length is limited to the smaller of itself and the level-2 value.
- R6: When `cur_lvl` is below 3 and level 3 is present, the length is further limited to the smaller of itself and the level-3 value.
- R7: When `vec_trap`=1 and `fp_trap`=0, `eff_len` is 0. When both are 1, or `vec_trap`=0, the normal computation applies.
- R8: A level whose presence input is 0 reads as zero, ignores writes, keeps its earlier stored value, and counts as zero when selected as the current level's own register.
- R9: `eff_len` shows the result for the inputs and register contents present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select (1, 2, 3; 0 unmapped) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DATA_W | Write data; only the low 4 bits are kept |
| rd_data | output | DATA_W | Read data of the selected register |
| lvl2_present | input | 1 | Level 2 is implemented |
| lvl3_present | input | 1 | Level 3 is implemented |
| cur_lvl | input | 2 | Current privilege level 0 to 3 |
| vec_trap | input | 1 | Vector unit accesses are trapped |
| fp_trap | input | 1 | Floating-point accesses are trapped |
| eff_len | output | LEN_W | Registered effective length code |

## Verification
The three registers are loaded with combinations drawn from {0, 3, 7, 9, 15}. For each combination the bench sweeps all four current levels, all four presence settings and all four trap pairs, so it can tell which register feeds the result, which caps apply and whether the trap forcing applies. Equal and reversed orderings of the values separate a correct minimum from a pass-through or an inverted compare. Write/read checks use data with upper bits set. They also cover writes to absent levels and to select 0, followed by re-enabling the level, which shows that the stored state was kept.

// File: rtl/vlen_ctrl.sv
module vlen_ctrl #(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lvl2_present,
  input  logic              lvl3_present,
  input  logic [1:0]        cur_lvl,
  input  logic              vec_trap,
  input  logic              fp_trap,
  output logic [LEN_W-1:0]  eff_len
);

  logic [LEN_W-1:0] len1_q, len2_q, len3_q;
  logic [LEN_W-1:0] len2_v, len3_v;
  logic [LEN_W-1:0] base, capped, eff_d;
  wire              unused_hi = ^wr_data[DATA_W-1:LEN_W];

  assign len2_v = lvl2_present ? len2_q : '0;
  assign len3_v = lvl3_present ? len3_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len1_q <= '0;
      len2_q <= '0;
      len3_q <= '0;
    end else if (wr_en) begin
      case (sel)
        2'd1: len1_q <= wr_data[LEN_W-1:0];
        2'd2: if (lvl2_present) len2_q <= wr_data[LEN_W-1:0];
        2'd3: if (lvl3_present) len3_q <= wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (sel)
      2'd1: rd_data[LEN_W-1:0] = len1_q;
      2'd2: rd_data[LEN_W-1:0] = len2_v;
      2'd3: rd_data[LEN_W-1:0] = len3_v;
      default: ;
    endcase
  end

  always_comb begin
    case (cur_lvl)
      2'd2:    base = len2_v;
      2'd3:    base = len3_v;
      default: base = len1_q;
    endcase
    capped = base;
    if (cur_lvl < 2'd2 && lvl2_present && len2_q < capped) capped = len2_q;
    if (cur_lvl < 2'd3 && lvl3_present && len3_q < capped) capped = len3_q;
  end

  assign eff_d = (vec_trap && !fp_trap) ? '0 : capped;

  always_ff @(posedge clk) begin
    if (!rst_n) eff_len <= '0;
    else        eff_len <= eff_d;
  end

endmodule

// File: rtl/vlen_ctrl_chk.sv
module vlen_ctrl_chk #(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              lvl2_present,
  input logic              lvl3_present,
  input logic [1:0]        cur_lvl,
  input logic              vec_trap,
  input logic              fp_trap,
  input logic [LEN_W-1:0]  eff_len,
  input logic [LEN_W-1:0]  len2_q,
  input logic [LEN_W-1:0]  len3_q
);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:LEN_W] == '0);

  p_unmapped_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0) |-> rd_data == '0);

  p_trap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_trap && !fp_trap) |=> eff_len == '0);

  p_absent_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd2 && !lvl2_present) |-> rd_data == '0);

  p_absent_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd2 && !lvl2_present) |=> $stable(len2_q));

  p_cap_l2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl2_present && cur_lvl < 2'd2) |=> eff_len <= $past(len2_q));

  p_cap_l3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl3_present && cur_lvl < 2'd3) |=> eff_len <= $past(len3_q));

endmodule

bind vlen_ctrl vlen_ctrl_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_data(rd_data),
  .lvl2_present(lvl2_present), .lvl3_present(lvl3_present),
  .cur_lvl(cur_lvl), .vec_trap(vec_trap), .fp_trap(fp_trap),
  .eff_len(eff_len), .len2_q(len2_q), .len3_q(len3_q)
);

// File: tb/sim_vlen_ctrl.sv
`timescale 1ns/1ps
module sim_vlen_ctrl;
  localparam int LEN_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        sel = '0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              lvl2_present = 1'b1;
  logic              lvl3_present = 1'b1;
  logic [1:0]        cur_lvl = '0;
  logic              vec_trap = 1'b0;
  logic              fp_trap = 1'b0;
  logic [LEN_W-1:0]  eff_len;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vlen_ctrl #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lvl2_present(lvl2_present), .lvl3_present(lvl3_present),
    .cur_lvl(cur_lvl), .vec_trap(vec_trap), .fp_trap(fp_trap), .eff_len(eff_len)
  );

  function automatic int model(int a, int b, int c, int lv, bit p2, bit p3, bit vt, bit ft);
    int v2 = p2 ? b : 0;
    int v3 = p3 ? c : 0;
    int r = (lv <= 1) ? a : (lv == 2) ? v2 : v3;
    if (vt && !ft) return 0;
    if (lv < 2 && p2 && b < r) r = b;
    if (lv < 3 && p3 && c < r) r = c;
    return r;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int s, int v);
    @(negedge clk);
    sel = 2'(s); wr_en = 1'b1; wr_data = 32'hA5A5_A5A0 | 32'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int s, int exp, string req);
    @(negedge clk);
    sel = 2'(s);
    #1 chk(req, rd_data, exp);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int vals[5] = '{0, 3, 7, 9, 15};
    repeat (3) @(negedge clk);
    chk("R3 eff_len", eff_len, 0);
    rst_n = 1'b1;
    for (int s = 1; s < 4; s++) rd(s, 0, "R3 reg");

    wr(1, 6); rd(1, 6, "R1 readback"); chk("R1 upper", rd_data[DATA_W-1:LEN_W], 0);
    wr(0, 11);
    rd(0, 0, "R2 sel0 read");
    rd(1, 6, "R2 sel0 write");
    rd(2, 0, "R2 sel0 write");
    rd(3, 0, "R2 sel0 write");
    wr(2, 5);
    @(negedge clk); lvl2_present = 1'b0;
    wr(2, 12);
    rd(2, 0, "R8 absent read");
    @(negedge clk); lvl2_present = 1'b1;
    rd(2, 5, "R8 absent write kept");

    foreach (vals[i]) foreach (vals[j]) foreach (vals[k]) begin
      @(negedge clk); lvl2_present = 1'b1; lvl3_present = 1'b1;
      wr(1, vals[i]); wr(2, vals[j]); wr(3, vals[k]);
      rd(3, vals[k], "R1 readback");
      for (int m = 0; m < 64; m++) begin
        int e;
        @(negedge clk);
        cur_lvl = 2'(m & 3);
        lvl2_present = m[2]; lvl3_present = m[3];
        vec_trap = m[4]; fp_trap = m[5];
        e = model(vals[i], vals[j], vals[k], m & 3, m[2], m[3], m[4], m[5]);
        @(negedge clk);
        chk("R4 R5 R6 R7 R8 R9 eff_len", eff_len, e);
      end
      vec_trap = 1'b0; fp_trap = 1'b0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule